// File: doc/BRIEF.md
# Field FIFO Read Port Controller

This block runs the read side of a field FIFO whose storage is a synchronous RAM with one cycle of read latency. It owns the read pointer and the output byte register with its drive enable. It also owns a flag that tells the reader whether unread data is waiting. Three control inputs are sampled on each rising clock: a pointer clear, a read advance and an output drive. A single polarity input makes all three, and the ready flag, either active high or active low.

A read advance with output drive off still moves the pointer, so unwanted bytes can be skipped without being shown. A clear that arrives while reads are stopped is stored and takes effect on the first edge where reads resume. The ready flag compares the read pointer with a write pointer that is already in the read clock domain. It reports data as waiting only when the writer is far enough ahead, and it never stops a read.

The RAM address port is driven from the pointer value that the coming edge will hold. This means the RAM word for pointer n is waiting at its data port on the edge that consumes n.

Top module: `fifo_rd_port`

## Requirements
- R1: On an edge with read advance active and no clear in effect, the pointer steps by one and wraps from the last address to 0. `ram_addr_o` always carries the pointer value that the next edge will store under the current inputs.
- R2: On an advancing edge with output drive inactive, the pointer still steps, and `dout_oe_o` is 0 after that edge.
- R3: On an edge with read advance inactive, the pointer keeps its value. `dout_o` keeps its last byte, and `dout_oe_o` follows the output drive control sampled at that edge.
- R4: On an edge with read advance and clear both active, the pointer becomes 0 and the output byte is not reloaded. The next advancing edge with drive active presents the RAM byte at address 0.
- R5: A clear sampled while read advance is inactive is stored and leaves the pointer unchanged. On the first later edge with read advance active, the pointer becomes 0 as in R4, and the stored clear is dropped.
- R6: With `pol_low_i` = 1, the clear, advance and drive inputs and `ready_o` are active low. With `pol_low_i` = 0 they are active high.
- R7: After each edge, the ready flag is active exactly when (write pointer sampled at that edge − read pointer after that edge) mod 2^ADDR_W is at least MIN_LAG. The flag never changes how a read behaves.
- R8: On an advancing edge with drive active and no clear in effect, `dout_o` loads the RAM byte at the address held by the pointer before that edge.
- R9: While `rst_n` is low and after it is released: the pointer is 0 (`ram_addr_o` = 0 when read advance is inactive), `dout_oe_o` = 0, no clear is stored, and the ready flag is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous global reset, active low |
| pol_low_i | input | 1 | 1: controls and ready flag active low; 0: active high |
| rd_clr_i | input | 1 | Read pointer clear (polarity per `pol_low_i`) |
| rd_adv_i | input | 1 | Read advance (polarity per `pol_low_i`) |
| out_drv_i | input | 1 | Output drive (polarity per `pol_low_i`) |
| wr_ptr_i | input | ADDR_W | Write pointer, already synchronized to `clk` |
| ram_addr_o | output | ADDR_W | Synchronous RAM read address |
| ram_data_i | input | DATA_W | RAM read data, one cycle after the address |
| dout_o | output | DATA_W | Registered output byte |
| dout_oe_o | output | 1 | Drive enable for `dout_o`; 0 means high impedance |
| ready_o | output | 1 | Unread data available (polarity per `pol_low_i`) |

## Verification
Two cases can land on the same edge. The first is a stored clear being applied while the advance that reads would otherwise make is replaced by the clear. The second is a skip, or a real read, whose pointer step pulls the ready flag across its threshold. The bench forces the first case by sampling a clear while stopped and then resuming with drive on. It forces the second with an LFSR that mixes clear, advance, drive and write-pointer values under both polarities. A reference model written from the requirements predicts the address, the held byte, the drive enable and the ready level after every edge. The byte presented after a resume must be the one at address 0, and the pointer must not have stepped on the resume edge.

// File: rtl/fifo_rd_pkg.sv
package fifo_rd_pkg;

    // What one read-clock edge does to the read state
    typedef enum logic [1:0] {
        RA_HOLD = 2'd0,   // reads stopped, nothing new
        RA_ARM  = 2'd1,   // reads stopped, remember a clear
        RA_ZERO = 2'd2,   // reads running, clear the pointer
        RA_STEP = 2'd3    // reads running, consume one address
    } rd_action_e;

endpackage

// File: rtl/rdp_pol_decode.sv
module rdp_pol_decode #(
    parameter int N_CTL = 3
) (
    input  logic             pol_low_i,
    input  logic [N_CTL-1:0] pin_i,
    output logic [N_CTL-1:0] act_o
);

    // Each control pin is active when it differs from the polarity level
    for (genvar g = 0; g < N_CTL; g++) begin : g_pin
        assign act_o[g] = pin_i[g] ^ pol_low_i;
    end

endmodule

// File: rtl/rdp_action.sv
module rdp_action
    import fifo_rd_pkg::*;
(
    input  logic       adv_i,
    input  logic       clr_i,
    input  logic       pend_i,
    output rd_action_e act_o
);

    always_comb begin
        if (adv_i) begin
            act_o = (clr_i || pend_i) ? RA_ZERO : RA_STEP;
        end else begin
            act_o = clr_i ? RA_ARM : RA_HOLD;
        end
    end

endmodule

// File: rtl/rdp_ready.sv
module rdp_ready #(
    parameter int ADDR_W  = 19,
    parameter int MIN_LAG = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_ptr_next_i,
    input  logic [ADDR_W-1:0] wr_ptr_i,
    output logic              ready_o
);

    localparam logic [ADDR_W-1:0] LAG_MIN = ADDR_W'(MIN_LAG);

    logic [ADDR_W-1:0] lag;
    logic              ready_d;
    logic              ready_q;

    always_comb begin
        lag     = wr_ptr_i - rd_ptr_next_i;
        ready_d = (lag >= LAG_MIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= ready_d;
        end
    end

    assign ready_o = ready_q;

    // A pointer pair with zero distance is never reported as ready
    AST_EQUAL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr_i == rd_ptr_next_i) |=> !ready_q) else $error("AST_EQUAL_NOT_READY"); // R7

endmodule

// File: rtl/fifo_rd_port.sv
module fifo_rd_port
    import fifo_rd_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 19,
    parameter int MIN_LAG = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pol_low_i,
    input  logic              rd_clr_i,
    input  logic              rd_adv_i,
    input  logic              out_drv_i,
    input  logic [ADDR_W-1:0] wr_ptr_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    input  logic [DATA_W-1:0] ram_data_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_oe_o,
    output logic              ready_o
);

    localparam int N_CTL   = 3;
    localparam int IDX_CLR = 0;
    localparam int IDX_ADV = 1;
    localparam int IDX_DRV = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              pend;
        logic [DATA_W-1:0] dout;
        logic              oe;
    } rd_state_t;

    rd_state_t        st_d;
    rd_state_t        st_q;
    logic [N_CTL-1:0] ctl_pin;
    logic [N_CTL-1:0] ctl_act;
    logic             clr_a;
    logic             adv_a;
    logic             drv_a;
    rd_action_e       act;
    logic             ready_int;

    assign ctl_pin[IDX_CLR] = rd_clr_i;
    assign ctl_pin[IDX_ADV] = rd_adv_i;
    assign ctl_pin[IDX_DRV] = out_drv_i;

    rdp_pol_decode #(.N_CTL(N_CTL)) u_pol (
        .pol_low_i (pol_low_i),
        .pin_i     (ctl_pin),
        .act_o     (ctl_act)
    );

    assign clr_a = ctl_act[IDX_CLR];
    assign adv_a = ctl_act[IDX_ADV];
    assign drv_a = ctl_act[IDX_DRV];

    rdp_action u_act (
        .adv_i  (adv_a),
        .clr_i  (clr_a),
        .pend_i (st_q.pend),
        .act_o  (act)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = drv_a;
        case (act)
            RA_ZERO: begin
                st_d.ptr  = '0;
                st_d.pend = 1'b0;
            end
            RA_STEP: begin
                st_d.ptr = st_q.ptr + 1'b1;
                if (drv_a) begin
                    st_d.dout = ram_data_i;
                end
            end
            RA_ARM: begin
                st_d.pend = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rdp_ready #(.ADDR_W(ADDR_W), .MIN_LAG(MIN_LAG)) u_rdy (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_ptr_next_i (st_d.ptr),
        .wr_ptr_i      (wr_ptr_i),
        .ready_o       (ready_int)
    );

    // RAM is addressed one edge ahead so its data lines up with the consume edge
    assign ram_addr_o = st_d.ptr;
    assign dout_o     = st_q.dout;
    assign dout_oe_o  = st_q.oe;
    assign ready_o    = ready_int ^ pol_low_i;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_a && !clr_a && !st_q.pend) |=> (st_q.ptr == ADDR_W'($past(st_q.ptr) + 1'b1)))
        else $error("AST_STEP_ONE"); // R1
    AST_SKIP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_a && !drv_a) |=> !dout_oe_o) else $error("AST_SKIP_HIZ"); // R2
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_a |=> ($stable(st_q.ptr) && $stable(dout_o))) else $error("AST_STOP_HOLDS"); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_a && (clr_a || st_q.pend)) |=> (st_q.ptr == '0 && !st_q.pend))
        else $error("AST_CLEAR_ZERO"); // R4
    AST_CLEAR_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_a && clr_a) |=> st_q.pend) else $error("AST_CLEAR_ARMS"); // R5

endmodule

// File: tb/fifo_rd_port_test.sv
module fifo_rd_port_test;

    localparam int CLK_P = 10;
    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int LAG   = 4;
    localparam int D     = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pol = 1'b0;
    logic          clr_p, adv_p, drv_p;
    logic [AW-1:0] wr = '0;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata = '0;
    logic [DW-1:0] dout;
    logic          doe, rdy_p;
    logic [DW-1:0] mem [D];

    int            m_ptr;
    bit            m_pend, m_oe, m_rdy;
    logic [DW-1:0] m_dout;
    int            checks = 0;
    int            errors = 0;
    bit            done = 0;
    logic [15:0]   lf = 16'hACE1;

    fifo_rd_port #(.DATA_W(DW), .ADDR_W(AW), .MIN_LAG(LAG)) uut (
        .clk(clk), .rst_n(rst_n), .pol_low_i(pol),
        .rd_clr_i(clr_p), .rd_adv_i(adv_p), .out_drv_i(drv_p),
        .wr_ptr_i(wr), .ram_addr_o(raddr), .ram_data_i(rdata),
        .dout_o(dout), .dout_oe_o(doe), .ready_o(rdy_p)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) rdata <= mem[raddr];

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(bit en, bit oe, bit rst);
        adv_p = en ^ pol;
        drv_p = oe ^ pol;
        clr_p = rst ^ pol;
    endtask

    task automatic model_reset();
        m_ptr = 0; m_pend = 0; m_oe = 0; m_rdy = 0; m_dout = '0;
    endtask

    // One edge: drive now (at a falling edge), update the model at the rising edge, check at the next falling edge
    task automatic cyc(bit en, bit oe, bit rst, string req);
        int exp_addr;
        drive(en, oe, rst);
        @(posedge clk);
        if (en) begin
            if (rst || m_pend) begin
                m_ptr = 0;
            end else begin
                if (oe) m_dout = mem[m_ptr];
                m_ptr = (m_ptr + 1) % D;
            end
            m_pend = 0;
        end else if (rst) begin
            m_pend = 1;
        end
        m_oe  = oe;
        m_rdy = ((int'(wr) - m_ptr + D) % D) >= LAG;
        #(CLK_P/2);
        if (en) exp_addr = (rst || m_pend) ? 0 : (m_ptr + 1) % D;
        else    exp_addr = m_ptr;
        chk(req, "ram_addr", int'(raddr), exp_addr);
        chk(req, "dout_oe", int'(doe), int'(m_oe));
        chk(req, "ready_pin", int'(rdy_p), int'(m_rdy ^ pol));
        if (m_oe) chk(req, "dout", int'(dout), int'(m_dout));
    endtask

    task automatic run_phase(bit p);
        @(negedge clk);
        rst_n = 1'b0;
        pol   = p;
        wr    = '0;
        drive(0, 0, 0);
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk("R9", "dout_oe", int'(doe), 0);
        chk("R9", "ready_pin", int'(rdy_p), int'(p));
        chk("R9", "ram_addr", int'(raddr), 0);
        @(negedge clk);
        cyc(1, 1, 1, "R4");
        // R1 R8: straight reads with wrap
        wr = AW'(20);
        for (int i = 0; i < 2 * D + 3; i++) cyc(1, 1, 0, (i % 2) ? "R1" : "R8");
        // R2: skipping with drive off on some edges
        for (int i = 0; i < 12; i++) cyc(1, (i % 3) != 0, 0, "R2");
        // R3: stopped, output held or released
        repeat (3) cyc(0, 1, 0, "R3");
        repeat (2) cyc(0, 0, 0, "R3");
        cyc(0, 1, 0, "R3");
        // R4: clear while running, drive off, then address 0 shown
        cyc(1, 0, 1, "R4");
        cyc(1, 1, 0, "R4");
        cyc(1, 1, 0, "R4");
        // R5: clear while stopped is deferred
        repeat (3) cyc(1, 1, 0, "R5");
        cyc(0, 1, 1, "R5");
        repeat (3) cyc(0, 1, 0, "R5");
        cyc(1, 1, 0, "R5");
        cyc(1, 1, 0, "R5");
        // R7: every write distance with the pointer still
        for (int w = 0; w < D; w++) begin
            wr = AW'(w);
            cyc(0, 1, 0, "R7");
        end
        // R7: reading with no data waiting still advances
        wr = AW'(m_ptr);
        repeat (4) cyc(1, 1, 0, "R7");
        // R6: mixed stimulus under this polarity
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            wr = lf[12:8];
            cyc(lf[0] | lf[1], lf[2], lf[3] & lf[4] & lf[5], "R6");
        end
    endtask

    initial begin
        for (int i = 0; i < D; i++) mem[i] = DW'(i * 37 + 5);
        drive(0, 0, 0);
        model_reset();
        run_phase(1'b0);
        run_phase(1'b1);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule